// File: doc/BRIEF.md
# Folded Min-Sum Check Node Processor

This block is the check-node stage of an LDPC decoder that uses the simplified comparison rule. It does not evaluate log or tanh terms. Each check node has eight incident edges, and the incoming edge messages are signed 8-bit log-likelihood values. The block scans the eight magnitudes and keeps the smallest value, the second-smallest value and the position of the smallest. It also keeps the parity of the sign bits. From these it forms one outgoing message per edge.

The minimum search is folded over a datapath of `LANES` messages per beat, where `LANES` is 1, 2, 4 or 8. A node therefore takes 8, 4, 2 or 1 accepted beats. A caller opens a node with `start` and streams the beats with `in_valid`. It then picks up all eight results on the cycle that `done` is high. The results stay in place until the next node completes.

Top module: `cn_minsum_fold`

## Requirements
- R1: After reset, `done` is 0 and every bit of `out_msg` is 0.
- R2: An input of -128 is treated as magnitude 127, so the output for any edge is never -128.
- R3: The output magnitude for edge i is the second-smallest input magnitude when edge i holds the smallest magnitude, and the smallest magnitude otherwise. Equal magnitudes give the same values whichever edge is chosen.
- R4: The output for edge i is negative exactly when the XOR of all eight input sign bits, XORed with the sign bit of input i, is 1. The output value is the two's complement negation of the magnitude (sign bit = bit 7 of each 8-bit message).
- R5: A node needs 8/LANES accepted beats. `done` is 1 for exactly the one cycle after the clock edge that takes the final beat. `out_msg` changes only on that edge and then holds its value.
- R6: `start` clears the accumulated state and opens a new node. If `in_valid` is also high in that cycle, that beat is the first beat. A `start` in the middle of a node discards the beats already taken.
- R7: A beat with `in_valid` high that arrives with no open node and no `start` is ignored: `done` stays 0 and `out_msg` is unchanged.
- R8: Beat k carries edges k*LANES to k*LANES+LANES-1, with lane j in bits [8j+7:8j] of `in_msg`. Output edge i is in bits [8i+7:8i] of `out_msg`.
- R9: Cycles with `in_valid` low inside an open node do not advance the beat count and do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a node and clears the search state |
| in_valid | input | 1 | A beat of LANES messages is present |
| in_msg | input | LANES*8 | Input edge messages, lane 0 in the low byte |
| done | output | 1 | One-cycle pulse when `out_msg` holds a new node result |
| out_msg | output | 64 | Output edge messages, edge 0 in the low byte |

## Verification
The hardest situations to create are those where the folded state must survive irregular stimulus. One is a node that is restarted part-way through, after beats with small magnitudes have already pulled the running minimum down. Another is a stray beat that arrives with no node open. The stimulus builds both on purpose. It aborts a node after two beats of zero-magnitude messages and then restarts it with larger values. It also streams valid beats after a completion without a `start`. Random nodes with idle gaps inserted between beats, and nodes whose `start` comes one cycle before the first beat, cover the rest of the handshake timing. Directed vectors cover saturation of -128 and the case where the minimum sits on the last edge of the last beat.

// File: rtl/cnmin_pkg.sv
package cnmin_pkg;
  localparam int MSG_W = 8;
  localparam int MAG_W = MSG_W - 1;
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  // magnitude of a two's complement message, clipped so -128 maps to 127
  function automatic logic [MAG_W-1:0] sat_mag(input logic [MSG_W-1:0] m);
    logic [MSG_W-1:0] a;
    a = m[MSG_W-1] ? (~m + 1'b1) : m;
    sat_mag = a[MSG_W-1] ? MAG_MAX : a[MAG_W-1:0];
  endfunction

  // sign plus magnitude back to two's complement
  function automatic logic [MSG_W-1:0] make_msg(input logic neg, input logic [MAG_W-1:0] mag);
    logic [MSG_W-1:0] e;
    e = {1'b0, mag};
    make_msg = neg ? (~e + 1'b1) : e;
  endfunction
endpackage

// File: rtl/cn_lane_fold.sv
// Folds one beat of LANES messages into the running min1/min2/index/parity.
// Lanes are visited in ascending edge order with a strict compare, so the
// lower edge index wins a tie for the minimum.
module cn_lane_fold
  import cnmin_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IW    = 3
) (
  input  logic [MAG_W-1:0]       m1_i,
  input  logic [MAG_W-1:0]       m2_i,
  input  logic [IW-1:0]          idx_i,
  input  logic                   par_i,
  input  logic [IW-1:0]          base_i,
  input  logic [LANES*MSG_W-1:0] lane_msg_i,
  output logic [MAG_W-1:0]       m1_o,
  output logic [MAG_W-1:0]       m2_o,
  output logic [IW-1:0]          idx_o,
  output logic                   par_o
);
  logic [MAG_W-1:0] mg;
  logic [IW-1:0]    pos;

  always_comb begin
    m1_o  = m1_i;
    m2_o  = m2_i;
    idx_o = idx_i;
    par_o = par_i;
    mg    = '0;
    pos   = '0;
    for (int j = 0; j < LANES; j++) begin
      mg  = sat_mag(lane_msg_i[j*MSG_W +: MSG_W]);
      pos = base_i + IW'(j);
      if (mg < m1_o) begin
        m2_o  = m1_o;
        m1_o  = mg;
        idx_o = pos;
      end else if (mg < m2_o) begin
        m2_o = mg;
      end
      par_o = par_o ^ lane_msg_i[j*MSG_W + MSG_W - 1];
    end
  end
endmodule

// File: rtl/cn_edge_out.sv
// Forms the outgoing message of every edge from the search result.
module cn_edge_out
  import cnmin_pkg::*;
#(
  parameter int DEG = 8,
  parameter int IW  = 3
) (
  input  logic [MAG_W-1:0]     m1_i,
  input  logic [MAG_W-1:0]     m2_i,
  input  logic [IW-1:0]        idx_i,
  input  logic                 par_i,
  input  logic [DEG-1:0]       sgn_i,
  output logic [DEG*MSG_W-1:0] msgs_o
);
  for (genvar g = 0; g < DEG; g++) begin : g_edge
    assign msgs_o[g*MSG_W +: MSG_W] =
      make_msg(par_i ^ sgn_i[g], (idx_i == IW'(g)) ? m2_i : m1_i);
  end
endmodule

// File: rtl/cn_minsum_fold.sv
module cn_minsum_fold
  import cnmin_pkg::*;
#(
  parameter int DEG   = 8,
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  input  logic [LANES*MSG_W-1:0] in_msg,
  output logic                   done,
  output logic [DEG*MSG_W-1:0]   out_msg
);
  localparam int BEATS = DEG / LANES;
  localparam int IW    = $clog2(DEG);
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic [MAG_W-1:0] m1_q, m2_q;
  logic [IW-1:0]    idx_q;
  logic             par_q;
  logic [DEG-1:0]   sgn_q;

  // named internal events
  logic             accept;
  logic             fin_beat;
  logic [CW-1:0]    cnt_use;
  logic [IW-1:0]    beat_base;

  // state the beat folds into: cleared on start (R6)
  logic [MAG_W-1:0] m1_b, m2_b, m1_n, m2_n;
  logic [IW-1:0]    idx_b, idx_n;
  logic             par_b, par_n;
  logic [DEG-1:0]   sgn_n;
  logic [DEG*MSG_W-1:0] res_msg;

  assign accept    = in_valid && (busy_q || start);   // R7
  assign cnt_use   = start ? '0 : cnt_q;
  assign fin_beat  = accept && (cnt_use == CW'(BEATS - 1));
  assign beat_base = IW'(int'(cnt_use) * LANES);      // R8

  assign m1_b  = start ? MAG_MAX : m1_q;
  assign m2_b  = start ? MAG_MAX : m2_q;
  assign idx_b = start ? '0 : idx_q;
  assign par_b = start ? 1'b0 : par_q;

  always_comb begin
    sgn_n = start ? '0 : sgn_q;
    for (int j = 0; j < LANES; j++)
      sgn_n[beat_base + IW'(j)] = in_msg[j*MSG_W + MSG_W - 1];
  end

  cn_lane_fold #(.LANES(LANES), .IW(IW)) u_fold (
    .m1_i(m1_b), .m2_i(m2_b), .idx_i(idx_b), .par_i(par_b),
    .base_i(beat_base), .lane_msg_i(in_msg),
    .m1_o(m1_n), .m2_o(m2_n), .idx_o(idx_n), .par_o(par_n)
  );

  cn_edge_out #(.DEG(DEG), .IW(IW)) u_out (
    .m1_i(m1_n), .m2_i(m2_n), .idx_i(idx_n), .par_i(par_n),
    .sgn_i(sgn_n), .msgs_o(res_msg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      m1_q    <= MAG_MAX;
      m2_q    <= MAG_MAX;
      idx_q   <= '0;
      par_q   <= 1'b0;
      sgn_q   <= '0;
      done    <= 1'b0;
      out_msg <= '0;
    end else begin
      done <= fin_beat;
      if (fin_beat)   busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      if (accept) begin
        m1_q  <= m1_n;
        m2_q  <= m2_n;
        idx_q <= idx_n;
        par_q <= par_n;
        sgn_q <= sgn_n;
        cnt_q <= fin_beat ? '0 : cnt_use + 1'b1;
      end else if (start) begin
        m1_q  <= MAG_MAX;
        m2_q  <= MAG_MAX;
        idx_q <= '0;
        par_q <= 1'b0;
        sgn_q <= '0;
        cnt_q <= '0;
      end
      if (fin_beat) out_msg <= res_msg;
    end
  end

  // magnitudes seen at the output, for the split check
  logic [DEG-1:0] m1_hit;
  always_comb
    for (int i = 0; i < DEG; i++)
      m1_hit[i] = (sat_mag(out_msg[i*MSG_W +: MSG_W]) == m1_q);

  a_r5_done_follows_final: assert property (@(posedge clk) disable iff (!rst_n)
    fin_beat |=> done);
  a_r5_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fin_beat));
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < BEATS);
  a_r3_min_order: assert property (@(posedge clk) disable iff (!rst_n)
    m2_q >= m1_q);
  a_r3_mag_split: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(m1_hit) >= DEG - 1));
  a_r7_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> !done);
  a_r2_no_minus128: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_msg[MSG_W-1:0] != 8'h80));
endmodule

// File: tb/cn_minsum_fold_bench.sv
module cn_minsum_fold_bench;
  localparam int DEG   = 8;
  localparam int LANES = 2;
  localparam int BEATS = DEG / LANES;
  localparam int LB    = LANES * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          in_valid = 1'b0;
  logic [LB-1:0] in_msg = '0;
  logic          done;
  logic [63:0]   out_msg;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cn_minsum_fold #(.DEG(DEG), .LANES(LANES)) u_cn_minsum_fold (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_msg(in_msg), .done(done), .out_msg(out_msg)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: locate the smallest edge first, then the smallest among the rest
  function automatic logic [63:0] model(input logic [63:0] v);
    int mag[8];
    bit neg[8];
    int best, bi, sec, m, val;
    bit prod;
    logic [63:0] r;
    best = 1000; bi = 0; sec = 1000; prod = 0; r = '0;
    for (int i = 0; i < 8; i++) begin
      logic signed [7:0] x;
      x = v[i*8 +: 8];
      neg[i] = x[7];
      mag[i] = (int'(x) < 0) ? -int'(x) : int'(x);
      if (mag[i] > 127) mag[i] = 127;
      prod ^= neg[i];
    end
    for (int i = 0; i < 8; i++)
      if (mag[i] < best) begin best = mag[i]; bi = i; end
    for (int i = 0; i < 8; i++)
      if (i != bi && mag[i] < sec) sec = mag[i];
    for (int i = 0; i < 8; i++) begin
      m   = (i == bi) ? sec : best;
      val = (prod ^ neg[i]) ? -m : m;
      r[i*8 +: 8] = 8'(val);
    end
    return r;
  endfunction

  task automatic drive(input logic s, input logic v, input logic [LB-1:0] d);
    @(negedge clk);
    start = s; in_valid = v; in_msg = d;
  endtask

  // lead: start alone one cycle before the first beat; gaps: idle cycles between beats
  task automatic run_node(input logic [63:0] v, input bit lead, input int gaps, input string req);
    logic [63:0] e;
    e = model(v);
    if (lead) drive(1'b1, 1'b0, LB'($urandom));
    for (int k = 0; k < BEATS; k++) begin
      drive((k == 0) && !lead, 1'b1, v[k*LB +: LB]);
      if (k > 0) chk(done == 1'b0, {req, " R5 early"}, 64'(done), 64'd0);
      if (k < BEATS - 1)
        for (int g = 0; g < gaps; g++) drive(1'b0, 1'b0, LB'($urandom));
    end
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk(done == 1'b1, {req, " R5 done"}, 64'(done), 64'd1);
    chk(out_msg == e, req, out_msg, e);
    @(negedge clk);
    chk(done == 1'b0 && out_msg == e, {req, " R5 hold"}, out_msg, e);
  endtask

  function automatic logic [63:0] rnd_vec();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] prev;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && out_msg == '0, "R1 reset", out_msg, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && out_msg == '0, "R1 after release", out_msg, 64'd0);

    run_node({8{8'd5}}, 0, 0, "R3 all equal");
    run_node({8{8'h80}}, 0, 0, "R2 all -128");
    run_node({8'd40, 8'd33, 8'd90, 8'd12, 8'h80, 8'd70, 8'd55, 8'd61}, 0, 0, "R2 one -128");
    run_node({8'hF0, 8'd9, 8'hE0, 8'd30, 8'hC5, 8'd17, 8'hFF, 8'd3}, 0, 0, "R4 mixed signs");
    run_node({8'd1, 8'd50, 8'd60, 8'd70, 8'd80, 8'd90, 8'd100, 8'd110}, 0, 0, "R8 min last edge");
    run_node({8'd99, 8'd98, 8'd97, 8'd96, 8'd95, 8'd94, 8'd93, 8'h02}, 1, 0, "R6 lead start");
    run_node(rnd_vec(), 0, 2, "R9 gaps");

    // R6: abort after two beats of zero magnitudes, then restart
    drive(1'b1, 1'b1, '0);
    drive(1'b0, 1'b1, '0);
    run_node({8'd20, 8'd21, 8'd22, 8'd23, 8'd24, 8'd25, 8'd26, 8'd27}, 0, 0, "R6 abort restart");

    // R7: beats with no open node leave everything alone
    prev = out_msg;
    for (int k = 0; k < BEATS + 1; k++) begin
      drive(1'b0, 1'b1, '0);
      if (k > 0) chk(done == 1'b0 && out_msg == prev, "R7 stray beat", out_msg, prev);
    end
    drive(1'b0, 1'b0, '0);
    @(negedge clk);
    chk(done == 1'b0 && out_msg == prev, "R7 stray end", out_msg, prev);

    for (int t = 0; t < 40; t++)
      run_node(rnd_vec(), ($urandom % 4) == 0, $urandom % 2, "R3 R4 R8 random");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule